// File: doc/BRIEF.md
# Commit-Protected Pin Function Selector

This block holds the per-line function selection for one 8-line I/O port. Each bit of an 8-bit select register hands its line either to software-controlled I/O (0) or to a dedicated peripheral function (1). The 8-bit `fn_sel` output drives the pin multiplexers directly. Software reaches the block over a simple synchronous register bus: address, write enable, write data, and registered read data.

Some lines carry functions that must survive careless software, such as debug-interface pins. These are marked by the `PROT_MASK` parameter. Protected select bits reset to 1. A write changes such a bit only when two things hold: the port has been opened with a 32-bit key written to the lock register, and that line's bit in the commit-enable register is set. Unprotected bits always follow the written data. Any non-key write to the lock register closes the port again.

Top module: `pinfn_guard`

## Requirements
- R1: After reset, `fn_sel` and the select register equal `PROT_MASK` (default 0x0F, so bits 3:0 are protected). The lock register reads 1 (locked), and the commit register reads the complement of `PROT_MASK` (0xF0).
- R2: A write to the select register at offset 0x420 sets every unprotected bit of `fn_sel` to the written data, in the cycle after the write edge.
- R3: While the port is locked, a write to the select register leaves every protected bit unchanged.
- R4: While the port is unlocked, a protected bit whose commit-enable bit is 0 is unchanged by a select write.
- R5: While the port is unlocked, a protected bit whose commit-enable bit is 1 takes the written data.
- R6: The lock register is at offset 0x520. Writing 0xC0DE5AFE unlocks the port. Writing any other value locks it. It reads 1 while locked and 0 while unlocked.
- R7: The commit-enable register is at offset 0x524 and holds 8 bits. A write to it is stored only while the port is unlocked. While locked, a write to it has no effect.
- R8: Read data appears one cycle after the address is presented and reflects register values before any write in that cycle. Bits 31:8 of every register read as 0, and unmapped offsets read as 0.
- R9: A read of the select register returns the value currently driven on `fn_sel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte offset of the register being accessed |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| fn_sel | output | 8 | Per-line peripheral function select, 1 = peripheral |

## Verification
The bound checker watches several rules on every cycle:
- protected bits hold through select writes while the port is locked;
- an unlocked write cannot move a protected bit whose commit bit is clear;
- unprotected bits follow the written data;
- commit-enable is frozen while locked;
- a non-key lock write always leaves the port locked;
- reserved read bits stay zero.

Some behaviour only the bench's scenarios can show. These are the reset values, the full lock–commit–write sequence in which a protected bit actually changes, the readback of each register, and the return to protected defaults after a reset in mid-run.

// File: rtl/pinfn_pkg.sv
package pinfn_pkg;

  // Next value of one select bit after a write that targets it.
  function automatic logic guarded_bit_next(
    input logic old_v,
    input logic new_v,
    input logic is_prot,
    input logic unlocked,
    input logic commit_en
  );
    if (!is_prot) return new_v;
    if (unlocked && commit_en) return new_v;
    return old_v;
  endfunction

  // True when a lock-register write carries the opening key.
  function automatic logic key_match(input logic [31:0] data, input logic [31:0] key);
    return data == key;
  endfunction

endpackage

// File: rtl/pinfn_lockreg.sv
module pinfn_lockreg #(
  parameter int          DATA_W = 32,
  parameter logic [31:0] KEY    = 32'hC0DE_5AFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic              locked
);
  import pinfn_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n)     locked <= 1'b1;
    else if (wr_en) locked <= !key_match(32'(wdata), KEY);
  end
endmodule

// File: rtl/pinfn_commitreg.sv
module pinfn_commitreg #(
  parameter int               LINES     = 8,
  parameter logic [LINES-1:0] PROT_MASK = 8'h0F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             unlocked,
  input  logic [LINES-1:0] wdata,
  output logic [LINES-1:0] commit
);
  always_ff @(posedge clk) begin
    if (!rst_n)                   commit <= ~PROT_MASK;
    else if (wr_en && unlocked)   commit <= wdata;
  end
endmodule

// File: rtl/pinfn_selbit.sv
module pinfn_selbit #(
  parameter bit PROTECTED = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic unlocked,
  input  logic commit_en,
  input  logic d,
  output logic q
);
  import pinfn_pkg::*;

  logic nxt;

  generate
    if (PROTECTED) begin : g_guarded
      assign nxt = guarded_bit_next(q, d, 1'b1, unlocked, commit_en);
    end else begin : g_open
      logic unused_in;
      assign unused_in = unlocked ^ commit_en;
      assign nxt = d;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)     q <= PROTECTED;
    else if (wr_en) q <= nxt;
  end
endmodule

// File: rtl/pinfn_guard.sv
module pinfn_guard #(
  parameter int               LINES     = 8,
  parameter int               ADDR_W    = 12,
  parameter int               DATA_W    = 32,
  parameter logic [LINES-1:0] PROT_MASK = 8'h0F,
  parameter logic [31:0]      KEY       = 32'hC0DE_5AFE,
  parameter logic [ADDR_W-1:0] SEL_OFF  = 12'h420,
  parameter logic [ADDR_W-1:0] LOCK_OFF = 12'h520,
  parameter logic [ADDR_W-1:0] CMT_OFF  = 12'h524
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [LINES-1:0]  fn_sel
);
  localparam int PAD_W = DATA_W - LINES;

  // Named decode events, also observed by the checker.
  logic sel_wr, lock_wr, cmt_wr;
  logic locked, unlocked;
  logic [LINES-1:0] commit;
  logic [DATA_W-1:0] rd_mux;

  assign sel_wr   = bus_we && (bus_addr == SEL_OFF);
  assign lock_wr  = bus_we && (bus_addr == LOCK_OFF);
  assign cmt_wr   = bus_we && (bus_addr == CMT_OFF);
  assign unlocked = !locked;

  pinfn_lockreg #(.DATA_W(DATA_W), .KEY(KEY)) u_lock (
    .clk(clk), .rst_n(rst_n), .wr_en(lock_wr), .wdata(bus_wdata), .locked(locked)
  );

  pinfn_commitreg #(.LINES(LINES), .PROT_MASK(PROT_MASK)) u_commit (
    .clk(clk), .rst_n(rst_n), .wr_en(cmt_wr), .unlocked(unlocked),
    .wdata(bus_wdata[LINES-1:0]), .commit(commit)
  );

  for (genvar i = 0; i < LINES; i++) begin : g_line
    pinfn_selbit #(.PROTECTED(PROT_MASK[i])) u_bit (
      .clk(clk), .rst_n(rst_n), .wr_en(sel_wr), .unlocked(unlocked),
      .commit_en(commit[i]), .d(bus_wdata[i]), .q(fn_sel[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == SEL_OFF)       rd_mux = {{PAD_W{1'b0}}, fn_sel};
    else if (bus_addr == LOCK_OFF) rd_mux = {{(DATA_W-1){1'b0}}, locked};
    else if (bus_addr == CMT_OFF)  rd_mux = {{PAD_W{1'b0}}, commit};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/pinfn_guard_chk.sv
module pinfn_guard_chk #(
  parameter int               LINES     = 8,
  parameter int               ADDR_W    = 12,
  parameter int               DATA_W    = 32,
  parameter logic [LINES-1:0] PROT_MASK = 8'h0F,
  parameter logic [31:0]      KEY       = 32'hC0DE_5AFE,
  parameter logic [ADDR_W-1:0] SEL_OFF  = 12'h420
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [LINES-1:0]  fn_sel,
  input logic              locked,
  input logic [LINES-1:0]  commit,
  input logic              sel_wr,
  input logic              lock_wr,
  input logic              cmt_wr
);
  assert_unprot_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> ((fn_sel & ~PROT_MASK) == ($past(bus_wdata[LINES-1:0]) & ~PROT_MASK)));

  assert_locked_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr && locked) |=> ((fn_sel & PROT_MASK) == ($past(fn_sel) & PROT_MASK)));

  assert_uncommitted_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr && !locked) |=> (((fn_sel ^ $past(fn_sel)) & PROT_MASK & ~$past(commit)) == '0));

  assert_relock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_wr && (32'(bus_wdata) != KEY)) |=> locked);

  assert_commit_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_wr && locked) |=> $stable(commit));

  assert_sel_pad_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == SEL_OFF) |=> (bus_rdata[DATA_W-1:LINES] == '0));
endmodule

bind pinfn_guard pinfn_guard_chk #(
  .LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .PROT_MASK(PROT_MASK), .KEY(KEY), .SEL_OFF(SEL_OFF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .fn_sel(fn_sel), .locked(locked), .commit(commit),
  .sel_wr(sel_wr), .lock_wr(lock_wr), .cmt_wr(cmt_wr)
);

// File: tb/test_pinfn_guard.sv
module test_pinfn_guard;
  localparam logic [11:0] A_SEL  = 12'h420;
  localparam logic [11:0] A_LOCK = 12'h520;
  localparam logic [11:0] A_CMT  = 12'h524;
  localparam logic [31:0] KEY    = 32'hC0DE_5AFE;

  // Row fields: lock_op(2: 0 none, 1 key, 2 other), commit wr, sel wr, exp sel, exp commit, exp locked
  localparam int NV = 5;
  localparam logic [34:0] VEC [NV] = '{
    {2'd0, 8'hFF, 8'hA0, 8'hAF, 8'hF0, 1'b1},  // R3, R7: locked
    {2'd1, 8'hF0, 8'h50, 8'h5F, 8'hF0, 1'b0},  // R4: unlocked, commit clear
    {2'd0, 8'hF3, 8'h30, 8'h3C, 8'hF3, 1'b0},  // R5 + R4 mixed
    {2'd2, 8'h00, 8'hC3, 8'hCC, 8'hF3, 1'b1},  // R3, R6, R7
    {2'd1, 8'h0F, 8'h00, 8'h00, 8'h0F, 1'b0}   // R5: all committed
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0] fn_sel;
  int checks = 0;
  int errors = 0;
  logic [31:0] rd;

  always #10 clk = ~clk;

  pinfn_guard i_pinfn_guard (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fn_sel(fn_sel)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rdreg(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 fn_sel", 32'(fn_sel), 32'h0F);
    rdreg(A_SEL, rd);  check("R1 sel read", rd, 32'h0F);
    rdreg(A_LOCK, rd); check("R1 lock read", rd, 32'h1);
    rdreg(A_CMT, rd);  check("R1 commit read", rd, 32'hF0);

    // Vector walk
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][34:33] == 2'd1) wr(A_LOCK, KEY);
      else if (VEC[v][34:33] == 2'd2) wr(A_LOCK, 32'h1234_5678);
      wr(A_CMT, {24'h0, VEC[v][32:25]});
      wr(A_SEL, {24'hFFFF_FF, VEC[v][24:17]});
      check("R2/R3/R4/R5 fn_sel", 32'(fn_sel), 32'(VEC[v][16:9]));
      rdreg(A_CMT, rd);  check("R7 commit", rd, 32'(VEC[v][8:1]));
      rdreg(A_LOCK, rd); check("R6 lock", rd, 32'(VEC[v][0]));
      rdreg(A_SEL, rd);  check("R9 sel read", rd, 32'(fn_sel));
    end

    // R8: unmapped offset, reserved bits zero
    rdreg(12'h000, rd); check("R8 unmapped", rd, 32'h0);
    rdreg(12'h424, rd); check("R8 unmapped near", rd, 32'h0);
    wr(A_SEL, 32'hFFFF_FFFF);
    rdreg(A_SEL, rd); check("R8 reserved zero", rd, 32'h0000_00FF);

    // R8: read reflects pre-write value in same cycle
    @(negedge clk);
    bus_addr = A_SEL; bus_we = 1'b1; bus_wdata = 32'h0000_0011;
    @(negedge clk);
    bus_we = 1'b0;
    check("R8 pre-write read", bus_rdata, 32'h0000_00FF);
    check("R2 after write", 32'(fn_sel), 32'h11);

    // R6: near-key value relocks
    wr(A_LOCK, KEY ^ 32'h1);
    rdreg(A_LOCK, rd); check("R6 near-key relock", rd, 32'h1);
    wr(A_SEL, 32'h0000_00FF);
    check("R3 held after relock", 32'(fn_sel), 32'hF1);

    // R1: reset in mid-run restores defaults
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R1 mid-run reset fn_sel", 32'(fn_sel), 32'h0F);
    rdreg(A_CMT, rd); check("R1 mid-run reset commit", rd, 32'hF0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule